// File: doc/BRIEF.md
# USB Host Interrupt Enable and Request Logic

This block sits in the register file of a USB host controller. It holds the 32-bit interrupt enable register that host software reaches over a single-cycle register bus. From the status bits the controller core reports, it produces one level-sensitive interrupt request line.

Software can only turn enable bits on through the bus. A write of 1 sets a bit, and a write of 0 does nothing to it. A separate clear vector, one bit per position, is the only way to turn bits off. The intended driver of that vector is a companion disable register. Bit 31 is the master enable, and it gates every per-event enable.

The request line is the output of a two-state machine. State `IRQ_IDLE` drives the line low. State `IRQ_RAISED` drives it high. The transition *raise* goes from `IRQ_IDLE` to `IRQ_RAISED` when a request is pending. The transition *drop* goes back when no request is pending. Each state holds while its condition is unchanged.

Top module: `usb_host_int_enable`

## Requirements
- R1: After the synchronous active-low reset, every enable bit reads 0 and `irq_o` is 0.
- R2: A bus write at address `REG_ADDR` sets each enable bit whose write-data bit is 1. The new value is readable from the next clock.
- R3: A write-data bit of 0 leaves the matching enable bit unchanged. This also applies to the master bit 31.
- R4: Only positions 0 to 6, 30 and 31 exist. Positions 7 to 29 always read 0, and writes to them are dropped.
- R5: With `bus_addr == REG_ADDR`, `bus_rdata` combinationally shows the enable register. At any other address it reads 0.
- R6: A write to any other address changes no enable bit.
- R7: A 1 in `clr_mask_i` clears that enable bit at the next clock. When a set and a clear hit the same bit in one cycle, the bit ends up 0.
- R8: `irq_o` is 1 one clock after the following condition holds, and 0 one clock after it fails. The condition is that bit 31 is set and, at some event position (0 to 6 or 30), both the status bit and the enable bit are 1.
- R9: While master bit 31 is 0, `irq_o` stays 0 whatever the status and per-event enables are.
- R10: Status bits at positions 7 to 29 and 31 never cause a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; a 1 sets the matching enable bit |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| clr_mask_i | input | 32 | Per-position clear, write-1-to-clear, beats a set |
| evt_status_i | input | 32 | Event status bits from the controller core |
| irq_o | output | 1 | Registered level interrupt request |

## Verification
The request path is tried with several status patterns, each separating one cause of error:
- All status bits high with every event enable on but the master off: shows whether the master gate is present.
- The same pattern with the master on: shows whether the one-clock latency is right.
- Status only in the non-event positions: shows whether those positions leak into the request.

The write path is tried with:
- All-ones writes: expose reserved positions that store data.
- All-zeros writes: expose writes that clear.
- Writes to a foreign address: expose a missing address decode.
- A set and a clear on the same bit: expose the wrong priority.

A long run of seeded random writes, addresses, clears and status vectors is then compared cycle by cycle with a bench model of the enable register and the request line.

// File: rtl/uhie_pkg.sv
package uhie_pkg;
    localparam int REG_W      = 32;
    localparam int MASTER_BIT = 31;
    // Positions that hold storage: per-event enables 0..6 and 30, master 31.
    localparam logic [REG_W-1:0] IMPL_MASK  = 32'hC000_007F;
    // Positions whose status can request an interrupt.
    localparam logic [REG_W-1:0] EVENT_MASK = 32'h4000_007F;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/uhie_enable_reg.sv
module uhie_enable_reg
    import uhie_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int REG_ADDR = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [REG_W-1:0]  clr_i,
    output logic [REG_W-1:0]  en_q
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

    logic hit;
    assign hit = wr_i && (addr_i == SEL);

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_store
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (clr_i[i])
                    bit_q <= 1'b0;
                else if (hit && wdata_i[i])
                    bit_q <= 1'b1;
            end
            assign en_q[i] = bit_q;
        end else begin : g_rsvd
            assign en_q[i] = 1'b0;
        end
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (en_q & ~IMPL_MASK) == '0);
    assert_write_no_clear_R3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(en_q) & ~$past(clr_i) & ~en_q) == '0);
    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(clr_i) & en_q) == '0);
    assert_foreign_addr_R6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !$past(hit) |-> ((en_q & ~$past(en_q)) == '0));
endmodule

// File: rtl/uhie_irq_fsm.sv
module uhie_irq_fsm
    import uhie_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] en_i,
    input  logic [REG_W-1:0] status_i,
    output logic             irq_o
);
    irq_state_e state_q, state_d;
    logic       req;

    assign req = en_i[MASTER_BIT] && (|(status_i & en_i & EVENT_MASK));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (req)  state_d = IRQ_RAISED;   // raise
            IRQ_RAISED: if (!req) state_d = IRQ_IDLE;     // drop
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_master_gate_R9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !$past(en_i[MASTER_BIT]) |-> !irq_o);
    assert_irq_latency_R8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        irq_o == $past(en_i[MASTER_BIT] && (|(status_i & en_i & EVENT_MASK))));
    assert_non_event_R10: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(status_i & EVENT_MASK) == '0) |-> !irq_o);
endmodule

// File: rtl/usb_host_int_enable.sv
module usb_host_int_enable
    import uhie_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int REG_ADDR = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       clr_mask_i,
    input  logic [31:0]       evt_status_i,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

    logic [REG_W-1:0] en_q;

    uhie_enable_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .clr_i   (clr_mask_i),
        .en_q    (en_q)
    );

    uhie_irq_fsm u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_q),
        .status_i (evt_status_i),
        .irq_o    (irq_o)
    );

    // R5: readback only at the register's own address.
    assign bus_rdata = (bus_addr == SEL) ? en_q : '0;
endmodule

// File: tb/tb_usb_host_int_enable.sv
module tb_usb_host_int_enable;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int REG_ADDR   = 8'h14;
    localparam logic [31:0] IMPL  = 32'hC000_007F;
    localparam logic [31:0] EVENT = 32'h4000_007F;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_wr;
    logic [31:0]       bus_wdata, bus_rdata, clr_mask_i, evt_status_i;
    logic              irq_o;

    int total = 0;
    int bad   = 0;
    logic [31:0] en_m;
    logic        irq_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_host_int_enable #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clr_mask_i(clr_mask_i),
        .evt_status_i(evt_status_i), .irq_o(irq_o)
    );

    function automatic logic [31:0] next_en(logic [31:0] cur, logic wr, logic [ADDR_W-1:0] a,
                                            logic [31:0] wd, logic [31:0] clr);
        logic [31:0] s;
        s = (wr && a == ADDR_W'(REG_ADDR)) ? (wd & IMPL) : 32'h0;
        return (cur | s) & ~clr;
    endfunction

    function automatic logic next_irq(logic [31:0] en, logic [31:0] st);
        return en[31] && (|(st & en & EVENT));
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a falling edge: drive inputs, advance model across one rising edge,
    // then return at the next falling edge.
    task automatic step(logic wr, logic [ADDR_W-1:0] a, logic [31:0] wd,
                        logic [31:0] clr, logic [31:0] st);
        logic [31:0] en_n;
        logic        irq_n;
        bus_wr = wr; bus_addr = a; bus_wdata = wd; clr_mask_i = clr; evt_status_i = st;
        en_n  = next_en(en_m, wr, a, wd, clr);
        irq_n = next_irq(en_m, st);
        @(posedge clk);
        en_m = en_n; irq_m = irq_n;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = ADDR_W'(REG_ADDR); clr_mask_i = '0;
        #1;
    endtask

    localparam logic [ADDR_W-1:0] RA = ADDR_W'(REG_ADDR);
    localparam logic [ADDR_W-1:0] OA = ADDR_W'(REG_ADDR + 4);

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog: got hung expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = RA; bus_wdata = '0;
        clr_mask_i = '0; evt_status_i = '0; en_m = '0; irq_m = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 enable reset", bus_rdata, 32'h0);
        check("R1 irq reset", {31'b0, irq_o}, 32'h0);

        step(1'b1, RA, 32'hFFFF_FFFF, '0, '0);
        check("R2 set all", bus_rdata, 32'hC000_007F);
        check("R4 reserved zero", bus_rdata & ~IMPL, 32'h0);
        step(1'b1, RA, 32'h0, '0, '0);
        check("R3 zero write keeps", bus_rdata, 32'hC000_007F);
        bus_addr = OA; #1;
        check("R5 foreign read zero", bus_rdata, 32'h0);
        step(1'b0, RA, '0, 32'hFFFF_FFFF, '0);
        check("R7 clear all", bus_rdata, 32'h0);
        step(1'b1, OA, 32'hFFFF_FFFF, '0, '0);
        check("R6 foreign write ignored", bus_rdata, 32'h0);
        step(1'b1, RA, 32'h4000_007F, 32'h0000_0004, '0);
        check("R7 clear beats set", bus_rdata, 32'h4000_007B);
        step(1'b0, RA, '0, '0, 32'hFFFF_FFFF);
        step(1'b0, RA, '0, '0, 32'hFFFF_FFFF);
        check("R9 master off no irq", {31'b0, irq_o}, 32'h0);
        step(1'b1, RA, 32'h8000_0000, '0, 32'hFFFF_FFFF);
        check("R8 no irq same cycle as master set", {31'b0, irq_o}, 32'h0);
        step(1'b0, RA, '0, '0, 32'hFFFF_FFFF);
        check("R8 irq after one clock", {31'b0, irq_o}, 32'h1);
        step(1'b0, RA, '0, '0, 32'hBFFF_FF80);
        check("R10 non-event status", {31'b0, irq_o}, 32'h0);
        step(1'b0, RA, '0, '0, 32'h4000_0000);
        check("R8 event bit 30", {31'b0, irq_o}, 32'h1);
        step(1'b0, RA, '0, 32'h8000_0000, 32'h4000_0000);
        step(1'b0, RA, '0, '0, 32'h4000_0000);
        check("R9 master cleared drops irq", {31'b0, irq_o}, 32'h0);

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] clr;
            clr = $urandom & $urandom & $urandom & $urandom;
            step(($urandom % 2) == 1, (($urandom % 4) == 0) ? OA : RA,
                 $urandom & $urandom, clr, $urandom & $urandom);
            check("R5 random readback", bus_rdata, en_m);
            check("R8 random irq", {31'b0, irq_o}, {31'b0, irq_m});
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule